// File: doc/BRIEF.md
# Fetch-Line Instruction Boundary Marker

This block sits in the front end of a processor that uses a variable-length instruction encoding built from 16-bit parcels. It accepts one 32-byte fetch line per cycle, which is sixteen parcels, and marks which parcels begin an instruction. It also reports each instruction's length. The length of an instruction is read from its first parcel by counting the run of ones that starts at the least-significant bit. Every parcel that begins an instruction is decoded this way, and the walk across the line follows from those lengths.

A 32-bit instruction whose first half is the last parcel of the line continues into the next line. The block keeps that first half and the fact that it is pending. The next accepted line then reports parcel 0 as a continuation and supplies the held parcel with it, so the extraction stage that follows can join the two halves.

Instructions of 48 and 64 bits are recognised but not supported. They raise a per-line flag, and the walk treats them as one parcel long. All results are registered, and a new line can be taken every cycle. A downstream ready signal stalls the stage without losing the pending carry. A flush drops the line in flight and clears the carry.

Top module: `boundary_marker`

## Requirements
- R1: A start parcel's length code is taken from the count of consecutive ones from bit 0: a count of 0 or 1 gives code 2'b00 (16-bit), 2 to 4 gives 2'b01 (32-bit), exactly 5 gives 2'b10 (48-bit), and 6 or more gives 2'b11 (64-bit).
- R2: Parcel 0 is a start unless the line is a continuation. The parcel after a start with code 2'b01 is not a start. Every other parcel is a start. Bit i of `mark_start` refers to parcel i, which is line bits [16i+15:16i].
- R3: `mark_len` bits [2i+1:2i] hold parcel i's length code when parcel i is a start, and 2'b00 when it is not. A non-start parcel's contents never affect any output.
- R4: When parcel 15 is a start with code 2'b01, `spill_out` is set. The next accepted line then reports `cont_in` = 1 and `mark_start[0]` = 0, and `held_parcel` equals the previous line's parcel 15.
- R5: A start whose count of ones is 5 or more sets `bad_len` for that line, and the parcel after it is a start.
- R6: Results appear one clock edge after the edge on which the line is accepted (`in_valid` and `in_ready` both high), and `out_valid` is then 1.
- R7: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0, all outputs hold, and the carry state is kept for the next accepted line.
- R8: With `flush` high, `in_ready` is 0. After the edge, `out_valid` is 0 and the next accepted line has `cont_in` = 0.
- R9: After synchronous reset, `out_valid` is 0, `in_ready` is 1, and the first accepted line has `cont_in` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drops the output line and clears the carry |
| in_valid | input | 1 | A fetch line is offered |
| in_line | input | 256 | Fetch line, with parcel i at bits [16i+15:16i] |
| in_ready | output | 1 | A line offered now is accepted at the edge |
| out_ready | input | 1 | Downstream takes the current result |
| out_valid | output | 1 | The result registers hold a line |
| mark_start | output | 16 | One bit per parcel, set where an instruction starts |
| mark_len | output | 32 | Two-bit length code per parcel |
| cont_in | output | 1 | Parcel 0 completes an instruction from the previous line |
| held_parcel | output | 16 | First half of that instruction, valid when cont_in is set |
| spill_out | output | 1 | Parcel 15 starts a 32-bit instruction continuing into the next line |
| bad_len | output | 1 | A start in this line has a 48-bit, 64-bit or longer length |

## Verification
Every marking result is due on the clock edge after the accepting edge. The bench therefore drives inputs on falling edges and reads the results on the falling edge that follows that next rising edge. A stall is checked by reading the same outputs on several falling edges while `out_ready` is low, and then checking that the waiting line appears one edge after the stall is released. A flush is checked one edge after it is raised, and its effect on the carry is checked on the next accepted line. Expected marks come from a bench model that counts trailing ones and walks the parcels as the requirements state, alongside hard-coded masks for chosen lines.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam logic [1:0] LEN16 = 2'b00;
  localparam logic [1:0] LEN32 = 2'b01;
  localparam logic [1:0] LEN48 = 2'b10;
  localparam logic [1:0] LEN64 = 2'b11;
  localparam int RUN_BITS = 7;
endpackage

// File: rtl/bm_len_classify.sv
module bm_len_classify
  import bm_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic [PW-1:0] parcel,
  output logic [1:0]    code,
  output logic          unsup
);
  logic [3:0] run;

  // count ones from bit 0, saturating at RUN_BITS
  always_comb begin
    logic going;
    run   = '0;
    going = 1'b1;
    for (int b = 0; b < RUN_BITS; b++) begin
      if (going && parcel[b]) run = run + 4'd1;
      else going = 1'b0;
    end
  end

  always_comb begin
    if (run <= 4'd1)      code = LEN16;
    else if (run <= 4'd4) code = LEN32;
    else if (run == 4'd5) code = LEN48;
    else                  code = LEN64;
    unsup = (run >= 4'd5);
  end

  always_comb begin
    if (!parcel[0] || !parcel[1]) begin
      AST_SHORT_FORM: assert (code == LEN16); // R1
    end
  end
endmodule

// File: rtl/bm_walk.sv
module bm_walk
  import bm_pkg::*;
#(
  parameter int NP = 16
) (
  input  logic                 cont,
  input  logic [NP-1:0][1:0]   code,
  input  logic [NP-1:0]        unsup,
  output logic [NP-1:0]        start,
  output logic [2*NP-1:0]      lens,
  output logic                 spill,
  output logic                 bad
);
  always_comb begin
    logic nxt;
    start = '0;
    lens  = '0;
    bad   = 1'b0;
    nxt   = !cont;
    for (int i = 0; i < NP; i++) begin
      start[i] = nxt;
      if (nxt) begin
        lens[2*i +: 2] = code[i];
        bad            = bad | unsup[i];
        nxt            = (code[i] != LEN32);
      end else begin
        nxt = 1'b1;
      end
    end
    spill = start[NP-1] && (code[NP-1] == LEN32);
  end
endmodule

// File: rtl/bm_carry.sv
module bm_carry #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          accept,
  input  logic          spill_next,
  input  logic [PW-1:0] last_parcel,
  output logic          cont_q,
  output logic [PW-1:0] head_q
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cont_q <= 1'b0;
      head_q <= '0;
    end else if (accept) begin
      cont_q <= spill_next;
      head_q <= last_parcel;
    end
  end

  AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!accept && !flush) |=> $stable(cont_q) && $stable(head_q)); // R7

  AST_FLUSH_DROPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    flush |=> !cont_q); // R8
endmodule

// File: rtl/boundary_marker.sv
module boundary_marker
  import bm_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int PW         = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic                      in_valid,
  input  logic [LINE_BYTES*8-1:0]   in_line,
  output logic                      in_ready,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [LINE_BYTES*8/PW-1:0]   mark_start,
  output logic [2*LINE_BYTES*8/PW-1:0] mark_len,
  output logic                      cont_in,
  output logic [PW-1:0]             held_parcel,
  output logic                      spill_out,
  output logic                      bad_len
);
  localparam int NP = LINE_BYTES * 8 / PW;

  logic                accept;
  logic [NP-1:0][1:0]  code;
  logic [NP-1:0]       unsup;
  logic [NP-1:0]       w_start;
  logic [2*NP-1:0]     w_lens;
  logic                w_spill;
  logic                w_bad;
  logic                cont_q;
  logic [PW-1:0]       head_q;

  assign in_ready = !flush && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  for (genvar g = 0; g < NP; g++) begin : g_cls
    bm_len_classify #(.PW(PW)) u_cls (
      .parcel (in_line[g*PW +: PW]),
      .code   (code[g]),
      .unsup  (unsup[g])
    );
  end

  bm_walk #(.NP(NP)) u_walk (
    .cont  (cont_q),
    .code  (code),
    .unsup (unsup),
    .start (w_start),
    .lens  (w_lens),
    .spill (w_spill),
    .bad   (w_bad)
  );

  bm_carry #(.PW(PW)) u_carry (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .accept      (accept),
    .spill_next  (w_spill),
    .last_parcel (in_line[(NP-1)*PW +: PW]),
    .cont_q      (cont_q),
    .head_q      (head_q)
  );

  always_ff @(posedge clk) begin
    if (rst || flush)   out_valid <= 1'b0;
    else if (accept)    out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_start  <= '0;
      mark_len    <= '0;
      cont_in     <= 1'b0;
      held_parcel <= '0;
      spill_out   <= 1'b0;
      bad_len     <= 1'b0;
    end else if (accept) begin
      mark_start  <= w_start;
      mark_len    <= w_lens;
      cont_in     <= cont_q;
      held_parcel <= head_q;
      spill_out   <= w_spill;
      bad_len     <= w_bad;
    end
  end

  AST_CONT_NOT_START: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cont_in) |-> !mark_start[0]); // R4

  AST_SPILL_IS_LAST32: assert property (@(posedge clk) disable iff (rst)
    (out_valid && spill_out) |-> (mark_start[NP-1] && mark_len[2*NP-1 -: 2] == LEN32)); // R4

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(mark_start)
      && $stable(mark_len) && $stable(cont_in) && $stable(bad_len))); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid); // R8

  for (genvar i = 0; i < NP; i++) begin : g_ast
    AST_IDLE_LEN_ZERO: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !mark_start[i]) |-> (mark_len[2*i +: 2] == LEN16)); // R3
    if (i < NP - 1) begin : g_follow
      AST_AFTER32_NOT_START: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mark_start[i] && mark_len[2*i +: 2] == LEN32) |-> !mark_start[i+1]); // R2
    end
  end
endmodule

// File: tb/tb_boundary_marker.sv
module tb_boundary_marker;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;

  logic         clk = 1'b0;
  logic         rst, flush, in_valid, out_ready;
  logic [255:0] in_line;
  logic         in_ready, out_valid, cont_in, spill_out, bad_len;
  logic [15:0]  mark_start, held_parcel;
  logic [31:0]  mark_len;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] pr [NP];
  logic        m_cont;
  logic [15:0] m_head;

  always #(CLK_PERIOD/2) clk = ~clk;

  boundary_marker dut (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_line(in_line),
    .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .mark_start(mark_start), .mark_len(mark_len), .cont_in(cont_in),
    .held_parcel(held_parcel), .spill_out(spill_out), .bad_len(bad_len)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] pack_line();
    logic [255:0] l;
    for (int i = 0; i < NP; i++) l[16*i +: 16] = pr[i];
    return l;
  endfunction

  function automatic logic [1:0] ref_code(input logic [15:0] p);
    int n = 0;
    while (n < 16 && p[n]) n++;
    if (n <= 1) return 2'b00;
    if (n <= 4) return 2'b01;
    if (n == 5) return 2'b10;
    return 2'b11;
  endfunction

  task automatic ref_walk(input logic cont, output logic [15:0] st,
                          output logic [31:0] ln, output logic sp, output logic bd);
    logic s = !cont;
    st = '0; ln = '0; bd = 1'b0;
    for (int i = 0; i < NP; i++) begin
      st[i] = s;
      if (s) begin
        ln[2*i +: 2] = ref_code(pr[i]);
        if (ref_code(pr[i]) >= 2'b10) bd = 1'b1;
        s = (ref_code(pr[i]) != 2'b01);
      end else s = 1'b1;
    end
    sp = st[15] && (ref_code(pr[15]) == 2'b01);
  endtask

  // offers pr as one line, reads the registered result one edge later
  task automatic send_and_check(input string req);
    logic [15:0] st; logic [31:0] ln; logic sp, bd;
    ref_walk(m_cont, st, ln, sp, bd);
    @(negedge clk);
    in_line  = pack_line();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "out_valid", 64'(out_valid), 64'd1);
    chk(req, "mark_start", 64'(mark_start), 64'(st));
    chk(req, "mark_len", 64'(mark_len), 64'(ln));
    chk(req, "cont_in", 64'(cont_in), 64'(m_cont));
    if (m_cont) chk(req, "held_parcel", 64'(held_parcel), 64'(m_head));
    chk(req, "spill_out", 64'(spill_out), 64'(sp));
    chk(req, "bad_len", 64'(bad_len), 64'(bd));
    m_cont = sp;
    m_head = pr[15];
  endtask

  task automatic fill(input logic [15:0] v);
    for (int i = 0; i < NP; i++) pr[i] = v;
  endtask

  task automatic t_reset();
    chk("R9", "out_valid after reset", 64'(out_valid), 64'd0);
    chk("R9", "in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_all_short();
    fill(16'h0001);
    pr[4] = 16'h0002;  // run of 0
    send_and_check("R1 R2 R6");
    chk("R2", "all starts", 64'(mark_start), 64'h0000_FFFF);
    chk("R3", "all short codes", 64'(mark_len), 64'd0);
  endtask

  task automatic t_all_wide();
    for (int i = 0; i < NP; i++) pr[i] = (i % 2 == 0) ? 16'h0003 : 16'hFFFF;
    send_and_check("R2 R3");
    chk("R2", "alternate starts", 64'(mark_start), 64'h0000_5555);
    chk("R3", "wide codes", 64'(mark_len), 64'h1111_1111);
    chk("R3", "halves not decoded", 64'(bad_len), 64'd0);
  endtask

  task automatic t_run_edges();
    fill(16'h0001);
    pr[0] = 16'h000F;  // run 4: 32-bit
    pr[1] = 16'h003F;  // second half, ignored
    pr[2] = 16'h001F;  // run 5: 48-bit
    pr[3] = 16'h0001;
    pr[5] = 16'h0000;
    send_and_check("R1 R5");
    chk("R1", "run4 code", 64'(mark_len[1:0]), 64'd1);
    chk("R1", "run5 code", 64'(mark_len[5:4]), 64'd2);
    chk("R5", "after 48 is start", 64'(mark_start[3]), 64'd1);
  endtask

  task automatic t_unsupported();
    fill(16'h0001);
    pr[3]  = 16'h001F;
    pr[7]  = 16'h003F;
    pr[10] = 16'h007F;
    send_and_check("R5");
    chk("R5", "every parcel starts", 64'(mark_start), 64'h0000_FFFF);
    chk("R5", "bad_len", 64'(bad_len), 64'd1);
    chk("R1", "run6 code", 64'(mark_len[15:14]), 64'd3);
    chk("R1", "run7 code", 64'(mark_len[21:20]), 64'd3);
  endtask

  task automatic t_spill();
    fill(16'h0001);
    pr[15] = 16'h0007;
    send_and_check("R4");
    chk("R4", "spill_out", 64'(spill_out), 64'd1);
    repeat (3) @(negedge clk);   // idle cycles keep the carry
    fill(16'h0001);
    pr[0] = 16'h003F;            // continuation, must not flag
    send_and_check("R4");
    chk("R4", "cont_in", 64'(cont_in), 64'd1);
    chk("R4", "parcel0 not start", 64'(mark_start), 64'h0000_FFFE);
    chk("R4", "held parcel", 64'(held_parcel), 64'h0007);
    chk("R3", "continuation ignored", 64'(bad_len), 64'd0);
  endtask

  task automatic t_stall();
    logic [15:0] st_a;
    fill(16'h0001);
    pr[15] = 16'h0003;
    @(negedge clk);
    out_ready = 1'b0;
    in_line   = pack_line();
    in_valid  = 1'b1;
    @(negedge clk);
    st_a = mark_start;
    chk("R7", "A held start", 64'(st_a), 64'h0000_FFFF);
    fill(16'h0002);
    in_line = pack_line();
    for (int k = 0; k < 3; k++) begin
      chk("R7", "in_ready low", 64'(in_ready), 64'd0);
      chk("R7", "outputs hold", 64'({out_valid, mark_start, spill_out}),
          64'({1'b1, st_a, 1'b1}));
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", "B after stall cont", 64'(cont_in), 64'd1);
    chk("R7", "B after stall start", 64'(mark_start), 64'h0000_FFFE);
    chk("R7", "B held parcel", 64'(held_parcel), 64'h0003);
    m_cont = 1'b0;
  endtask

  task automatic t_flush();
    fill(16'h0001);
    pr[15] = 16'h0003;
    send_and_check("R8");
    @(negedge clk);
    flush = 1'b1;
    in_valid = 1'b1;
    #1;
    chk("R8", "in_ready during flush", 64'(in_ready), 64'd0);
    @(negedge clk);
    flush = 1'b0;
    in_valid = 1'b0;
    chk("R8", "out_valid after flush", 64'(out_valid), 64'd0);
    m_cont = 1'b0;
    fill(16'h0001);
    send_and_check("R8");
    chk("R8", "carry cleared", 64'(cont_in), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; flush = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_line = '0;
    m_cont = 1'b0; m_head = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_all_short();
    t_all_wide();
    t_run_edges();
    t_unsupported();
    t_spill();
    t_stall();
    t_flush();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule